// File: doc/BRIEF.md
# ECC Engine Register Front-End

This block is the memory-mapped control and status front-end of a block error-correction engine. Software programs a byte count, selects encode or correct mode, and then streams single bytes into a data port. The front-end counts the bytes it accepts. When the programmed count is reached it raises the finished flag for the active mode. During a correcting pass it also records whether every byte was 0x00 or every byte was 0xFF, so that software can skip correction on erased or blank blocks.

The arithmetic core sits outside this block. The core's parity words, error-position list, error counts and uncorrectable indication arrive on a sideband input. Software reads parity and error positions directly through word-aligned register offsets. When a correcting pass finishes, the counts and the error and uncorrectable indications are captured into the status register.

The control register cannot be written in place. Software changes it only through a write-1-to-set alias and a write-1-to-clear alias. The status register is write-1-to-clear. An interrupt line is raised whenever a status flag is set and its enable bit is also set.

Top module: `eccfe_top`

## Requirements
- R1: After reset, the control, count, status and interrupt-enable registers all read zero, and `irq` is low.
- R2: The control register reads at offset 0x00 and holds these bits: bit0 engine enable, bit1 init, bit2 strength select, bit3 encode mode (1 = compute parity, 0 = correct). A write to 0x04 ORs the written ones into the register. A write to 0x08 clears the bits written as one. Writing 0x1F to 0x08 clears every bit. A write to 0x00 has no effect.
- R3: When init is set, the next clock clears the byte counter and re-arms the all-0x00 and all-0xFF trackers. The same clock returns init to zero unless a new set-alias write sets it again.
- R4: The count register at 0x0C holds the encode byte count in bits 9:0 and the decode byte count in bits 25:16. In encode mode, accepting the encode count of bytes sets status bit2. In correct mode, accepting the decode count of bytes sets status bit3. The flag is visible one cycle after the final byte is written. A count of zero never completes.
- R5: A write to the data port at 0x10 supplies one byte in bits 7:0. The byte is ignored while enable is 0, while init is 1, or once the programmed count has already been reached.
- R6: When a correcting pass completes, status bit4 is set if every accepted byte was 0xFF, and status bit5 is set if every accepted byte was 0x00. Encode passes never set bit4 or bit5.
- R7: When a correcting pass completes, the block captures the sideband values into the status register. The corrected-error count goes to bits 31:28 and the total error count to bits 22:16. Bit1 is set if the uncorrectable input is high. Bit0 is set if the total is nonzero or the pass is uncorrectable. Encode passes capture none of these.
- R8: Status at 0x24 is write-1-to-clear on bits 5:0. Writing 1 to bit3 also zeroes both count fields. A flag that is set and cleared in the same cycle stays set.
- R9: Parity word k reads at 0x14+4k from sideband word k. Error-index word k reads at 0x28+4k. Its bits 12:0 hold sideband index 2k and its bits 28:16 hold index 2k+1, with all other bits zero. The alias offsets and unmapped offsets read zero.
- R10: The interrupt-enable register at 0x38 takes a plain write of bits 5:0. The alias at 0x3C sets enable bits and the alias at 0x40 clears them. `irq` is high exactly when a status bit in 5:0 and its enable bit are both one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 7 | Byte offset of the access, word aligned |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| parityIn | input | NPAR*32 | Parity words from the arithmetic core |
| errIdxIn | input | NIDX*26 | Packed 13-bit error bit positions, index i at bits 13i+12:13i |
| errCntIn | input | 4 | Corrected-error count from the core |
| errTotIn | input | 7 | Total error count from the core |
| uncorIn | input | 1 | Core reports the block as uncorrectable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that each write strobe lasts one cycle with a stable offset. They also assume that the sideband counts are valid in the cycle the final byte of a correcting pass is written. The bench drives the sideband before starting each pass and holds it until the status has been read back. Every write is issued on the falling edge and held for exactly one cycle. Each pass is restarted through the clear alias followed by an init write, so no assertion sees a half-configured engine.

// File: rtl/eccfe_pkg.sv
package eccfe_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 10;
  localparam int IDX_W  = 13;
  localparam int ST_W   = 6;
  localparam int CTL_W  = 4;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_CTL    = 7'h00;
  localparam logic [ADDR_W-1:0] OFS_CTLSET = 7'h04;
  localparam logic [ADDR_W-1:0] OFS_CTLCLR = 7'h08;
  localparam logic [ADDR_W-1:0] OFS_CNT    = 7'h0C;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 7'h10;
  localparam logic [ADDR_W-1:0] OFS_PAR    = 7'h14;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 7'h24;
  localparam logic [ADDR_W-1:0] OFS_IDX    = 7'h28;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 7'h38;
  localparam logic [ADDR_W-1:0] OFS_IENSET = 7'h3C;
  localparam logic [ADDR_W-1:0] OFS_IENCLR = 7'h40;

  // control bit positions
  localparam int C_EN   = 0;
  localparam int C_INIT = 1;
  localparam int C_STR  = 2;
  localparam int C_ENC  = 3;

  // status flag positions
  localparam int S_ERR  = 0;
  localparam int S_UNC  = 1;
  localparam int S_ENCF = 2;
  localparam int S_DECF = 3;
  localparam int S_ONES = 4;
  localparam int S_ZERO = 5;

  typedef struct packed {
    logic             ctlEn;
    logic             ctlInit;
    logic             encMode;
    logic             dataWr;
    logic [7:0]       dataByte;
    logic [CNT_W-1:0] target;
    logic [ST_W-1:0]  stClr;
  } strobe_t;
endpackage

// File: rtl/eccfe_dpath.sv
module eccfe_dpath
  import eccfe_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [3:0]    errCntIn,
  input  logic [6:0]    errTotIn,
  input  logic          uncorIn,
  output logic [DATA_W-1:0] statusWord
);
  logic [CNT_W-1:0] byteCnt;
  logic             allOnesQ, allZerosQ;
  logic [ST_W-1:0]  flagsQ;
  logic [3:0]       errcQ;
  logic [6:0]       terrQ;

  logic             accept, lastByte, onesNow, zerosNow;
  logic [ST_W-1:0]  setMask;

  assign accept   = strb.dataWr && strb.ctlEn && !strb.ctlInit && (byteCnt < strb.target);
  assign lastByte = accept && (CNT_W'(byteCnt + 1'b1) == strb.target);
  assign onesNow  = allOnesQ  && (strb.dataByte == 8'hFF);
  assign zerosNow = allZerosQ && (strb.dataByte == 8'h00);

  always_comb begin
    setMask = '0;
    if (lastByte) begin
      if (strb.encMode) begin
        setMask[S_ENCF] = 1'b1;
      end else begin
        setMask[S_DECF] = 1'b1;
        setMask[S_ONES] = onesNow;
        setMask[S_ZERO] = zerosNow;
        setMask[S_UNC]  = uncorIn;
        setMask[S_ERR]  = uncorIn || (errTotIn != 7'd0);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt   <= '0;
      allOnesQ  <= 1'b1;
      allZerosQ <= 1'b1;
    end else if (strb.ctlInit) begin
      byteCnt   <= '0;
      allOnesQ  <= 1'b1;
      allZerosQ <= 1'b1;
    end else if (accept) begin
      byteCnt   <= byteCnt + 1'b1;
      allOnesQ  <= onesNow;
      allZerosQ <= zerosNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
      errcQ  <= '0;
      terrQ  <= '0;
    end else begin
      flagsQ <= (flagsQ & ~strb.stClr) | setMask;
      if (setMask[S_DECF]) begin
        errcQ <= errCntIn;
        terrQ <= errTotIn;
      end else if (strb.stClr[S_DECF]) begin
        errcQ <= '0;
        terrQ <= '0;
      end
    end
  end

  assign statusWord = {errcQ, 5'd0, terrQ, 10'd0, flagsQ};

  // R5: with the engine off and no init, the byte counter never moves
  a_r5_off_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ctlEn && !strb.ctlInit) |=> $stable(byteCnt));

  // R4: a finished flag only rises right after an accepted byte
  a_r4_done_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagsQ[S_DECF]) |-> $past(accept));

  // R6: all-ones flag only appears together with decode finished
  a_r6_ones_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagsQ[S_ONES]) |-> flagsQ[S_DECF]);

  // R3: init always empties the counter on the following cycle
  a_r3_init_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctlInit |=> (byteCnt == '0));
endmodule

// File: rtl/eccfe_ctrl.sv
module eccfe_ctrl
  import eccfe_pkg::*;
#(
  parameter int NPAR = 4,
  parameter int NIDX = 4
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [DATA_W-1:0]       regWdata,
  input  logic [NPAR*DATA_W-1:0]  parityIn,
  input  logic [NIDX*2*IDX_W-1:0] errIdxIn,
  input  logic [DATA_W-1:0]       statusWord,
  output strobe_t                 strb,
  output logic [DATA_W-1:0]       regRdata,
  output logic                    irq
);
  localparam int IDX_PAD = 16 - IDX_W;

  logic [CTL_W-1:0] ctrlQ, ctrlNext;
  logic [ST_W-1:0]  intEnQ;
  logic [CNT_W-1:0] encCntQ, decCntQ;
  logic wrSet, wrClr, wrCnt, wrData, wrStat, wrIen, wrIenSet, wrIenClr;
  logic unusedOk;

  assign wrSet    = regWe && (regAddr == OFS_CTLSET);
  assign wrClr    = regWe && (regAddr == OFS_CTLCLR);
  assign wrCnt    = regWe && (regAddr == OFS_CNT);
  assign wrData   = regWe && (regAddr == OFS_DATA);
  assign wrStat   = regWe && (regAddr == OFS_STAT);
  assign wrIen    = regWe && (regAddr == OFS_IEN);
  assign wrIenSet = regWe && (regAddr == OFS_IENSET);
  assign wrIenClr = regWe && (regAddr == OFS_IENCLR);
  assign unusedOk = ^{regWdata[31:26], regWdata[15:10]};

  always_comb begin
    ctrlNext = ctrlQ;
    ctrlNext[C_INIT] = 1'b0;
    if (wrSet) ctrlNext = ctrlNext | regWdata[CTL_W-1:0];
    if (wrClr) ctrlNext = ctrlNext & ~regWdata[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      intEnQ  <= '0;
      encCntQ <= '0;
      decCntQ <= '0;
    end else begin
      ctrlQ <= ctrlNext;
      if (wrIen)         intEnQ <= regWdata[ST_W-1:0];
      else if (wrIenSet) intEnQ <= intEnQ | regWdata[ST_W-1:0];
      else if (wrIenClr) intEnQ <= intEnQ & ~regWdata[ST_W-1:0];
      if (wrCnt) begin
        encCntQ <= regWdata[CNT_W-1:0];
        decCntQ <= regWdata[16 +: CNT_W];
      end
    end
  end

  always_comb begin
    strb.ctlEn    = ctrlQ[C_EN];
    strb.ctlInit  = ctrlQ[C_INIT];
    strb.encMode  = ctrlQ[C_ENC];
    strb.dataWr   = wrData;
    strb.dataByte = regWdata[7:0];
    strb.target   = ctrlQ[C_ENC] ? encCntQ : decCntQ;
    strb.stClr    = wrStat ? regWdata[ST_W-1:0] : '0;
  end

  // error-index words: two positions per word
  logic [DATA_W-1:0] idxWord [NIDX];
  for (genvar k = 0; k < NIDX; k++) begin : g_idx
    assign idxWord[k] = {{IDX_PAD{1'b0}}, errIdxIn[(2*k+1)*IDX_W +: IDX_W],
                         {IDX_PAD{1'b0}}, errIdxIn[(2*k)*IDX_W +: IDX_W]};
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_CTL:  regRdata = {{(DATA_W-CTL_W){1'b0}}, ctrlQ};
      OFS_CNT:  regRdata = {6'd0, decCntQ, 6'd0, encCntQ};
      OFS_STAT: regRdata = statusWord;
      OFS_IEN:  regRdata = {{(DATA_W-ST_W){1'b0}}, intEnQ};
      default:  regRdata = '0;
    endcase
    for (int k = 0; k < NPAR; k++)
      if (regAddr == ADDR_W'(OFS_PAR + 4*k)) regRdata = parityIn[k*DATA_W +: DATA_W];
    for (int k = 0; k < NIDX; k++)
      if (regAddr == ADDR_W'(OFS_IDX + 4*k)) regRdata = idxWord[k];
  end

  assign irq = |(statusWord[ST_W-1:0] & intEnQ);

  // R3: init falls back to zero one cycle after it was set
  a_r3_init_selfclear: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[C_INIT] && !(wrSet && regWdata[C_INIT])) |=> !ctrlQ[C_INIT]);

  // R2: without an alias write the persistent control bits hold
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrSet || wrClr) |=> $stable({ctrlQ[C_ENC], ctrlQ[C_STR], ctrlQ[C_EN]}));
endmodule

// File: rtl/eccfe_top.sv
module eccfe_top
  import eccfe_pkg::*;
#(
  parameter int NPAR = 4,
  parameter int NIDX = 4
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [DATA_W-1:0]       regWdata,
  output logic [DATA_W-1:0]       regRdata,
  input  logic [NPAR*DATA_W-1:0]  parityIn,
  input  logic [NIDX*2*IDX_W-1:0] errIdxIn,
  input  logic [3:0]              errCntIn,
  input  logic [6:0]              errTotIn,
  input  logic                    uncorIn,
  output logic                    irq
);
  strobe_t           strb;
  logic [DATA_W-1:0] statusWord;

  eccfe_ctrl #(.NPAR(NPAR), .NIDX(NIDX)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .parityIn(parityIn), .errIdxIn(errIdxIn),
    .statusWord(statusWord), .strb(strb), .regRdata(regRdata), .irq(irq)
  );

  eccfe_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .errCntIn(errCntIn),
    .errTotIn(errTotIn), .uncorIn(uncorIn), .statusWord(statusWord)
  );

  // R10: irq never rises while every enable bit is zero
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl_i.intEnQ == '0) |-> !irq);
endmodule

// File: tb/eccfe_top_tb_top.sv
`timescale 1ns/1ps
module eccfe_top_tb_top;
  localparam int NPAR = 4;
  localparam int NIDX = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [6:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [NPAR*32-1:0] parityIn;
  logic [NIDX*26-1:0] errIdxIn;
  logic [3:0] errCntIn = '0;
  logic [6:0] errTotIn = '0;
  logic uncorIn = 1'b0;
  logic irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  eccfe_top #(.NPAR(NPAR), .NIDX(NIDX)) dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .parityIn(parityIn),
    .errIdxIn(errIdxIn), .errCntIn(errCntIn), .errTotIn(errTotIn),
    .uncorIn(uncorIn), .irq(irq)
  );

  typedef struct packed {
    logic        enc;
    logic [9:0]  cnt;
    logic [7:0]  fill;
    logic [7:0]  last;
    logic [3:0]  errc;
    logic [6:0]  tot;
    logic        unc;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 10'd5, 8'h00, 8'h00, 4'd0, 7'd0, 1'b0, 32'h0000_0004},
    '{1'b0, 10'd6, 8'hFF, 8'hFF, 4'd0, 7'd0, 1'b0, 32'h0000_0018},
    '{1'b0, 10'd6, 8'h00, 8'h00, 4'd0, 7'd0, 1'b0, 32'h0000_0028},
    '{1'b0, 10'd6, 8'h00, 8'h01, 4'd3, 7'd3, 1'b0, 32'h3003_0009},
    '{1'b0, 10'd4, 8'hFF, 8'hFE, 4'd0, 7'd9, 1'b1, 32'h0009_000B},
    '{1'b1, 10'd1, 8'hFF, 8'hFF, 4'd0, 7'd0, 1'b0, 32'h0000_0004},
    '{1'b0, 10'd3, 8'h55, 8'h55, 4'd0, 7'd0, 1'b0, 32'h0000_0008},
    '{1'b1, 10'd2, 8'hAA, 8'hAA, 4'd7, 7'd5, 1'b1, 32'h0000_0004}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic startPass(input logic enc, input logic [31:0] cntWord);
    wr(7'h08, 32'h1F);
    wr(7'h04, {28'd0, enc, 3'b011});
    wr(7'h0C, cntWord);
  endtask

  function automatic logic [12:0] idxVal(input int i);
    return 13'(i * 613 + 17);
  endfunction

  initial begin
    for (int k = 0; k < NPAR; k++) parityIn[k*32 +: 32] = 32'hA5A5_0000 + 32'(k * 4099);
    for (int i = 0; i < 2*NIDX; i++) errIdxIn[i*13 +: 13] = idxVal(i);
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(7'h00, v); chk("R1 ctrl", v, 0);
    rd(7'h0C, v); chk("R1 count", v, 0);
    rd(7'h24, v); chk("R1 status", v, 0);
    rd(7'h38, v); chk("R1 inten", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 set/clear aliases
    wr(7'h04, 32'h0C); rd(7'h00, v); chk("R2 set", v, 32'h0C);
    wr(7'h04, 32'h01); rd(7'h00, v); chk("R2 set or", v, 32'h0D);
    wr(7'h08, 32'h04); rd(7'h00, v); chk("R2 clear", v, 32'h09);
    wr(7'h00, 32'hFF); rd(7'h00, v); chk("R2 direct write ignored", v, 32'h09);
    wr(7'h08, 32'h1F); rd(7'h00, v); chk("R2 clear all", v, 0);
    rd(7'h04, v); chk("R9 alias reads zero", v, 0);

    // R3 init self-clears
    wr(7'h04, 32'h02); rd(7'h00, v); chk("R3 init set", v, 32'h02);
    @(negedge clk); rd(7'h00, v); chk("R3 init selfclear", v, 0);

    // vector table: R4 R6 R7 R8
    for (int n = 0; n < 8; n++) begin
      errCntIn = VEC[n].errc; errTotIn = VEC[n].tot; uncorIn = VEC[n].unc;
      if (VEC[n].enc) startPass(1'b1, {6'd0, VEC[n].cnt + 10'd7, 6'd0, VEC[n].cnt});
      else            startPass(1'b0, {6'd0, VEC[n].cnt, 16'd1});
      for (int b = 0; b < VEC[n].cnt; b++)
        wr(7'h10, {24'd0, (b == VEC[n].cnt - 1) ? VEC[n].last : VEC[n].fill});
      rd(7'h24, v); chk("R4 R6 R7 vector status", v, VEC[n].exp);
      wr(7'h24, v); rd(7'h24, v); chk("R8 writeback clears", v, 0);
    end

    // R5 ignored while disabled, then counting resumes from zero
    errCntIn = 0; errTotIn = 0; uncorIn = 0;
    startPass(1'b0, {6'd0, 10'd3, 16'd0});
    wr(7'h08, 32'h01);
    for (int b = 0; b < 3; b++) wr(7'h10, 32'h00);
    rd(7'h24, v); chk("R5 disabled no done", v, 0);
    wr(7'h04, 32'h01);
    wr(7'h10, 32'h00); wr(7'h10, 32'h00);
    rd(7'h24, v); chk("R5 disabled bytes not counted", v, 0);
    wr(7'h10, 32'h00);
    rd(7'h24, v); chk("R5 done after enable", v, 32'h28);
    wr(7'h24, 32'h3F);
    wr(7'h10, 32'hFF);
    rd(7'h24, v); chk("R5 extra byte ignored", v, 0);

    // R3 init mid-pass restarts counter and trackers
    startPass(1'b0, {6'd0, 10'd4, 16'd0});
    wr(7'h10, 32'hFF); wr(7'h10, 32'hFF);
    wr(7'h04, 32'h02);
    for (int b = 0; b < 3; b++) wr(7'h10, 32'h00);
    rd(7'h24, v); chk("R3 init restarts count", v, 0);
    wr(7'h10, 32'h00);
    rd(7'h24, v); chk("R3 R6 trackers rearmed", v, 32'h28);

    // R8 partial clear, R10 interrupt
    wr(7'h24, 32'h08); rd(7'h24, v); chk("R8 partial clear", v, 32'h20);
    @(negedge clk); chk("R10 irq masked", {31'd0, irq}, 0);
    wr(7'h3C, 32'h20); @(negedge clk); chk("R10 irq on", {31'd0, irq}, 1);
    wr(7'h40, 32'h20); @(negedge clk); chk("R10 irq cleared by enable", {31'd0, irq}, 0);
    wr(7'h38, 32'h3F); rd(7'h38, v); chk("R10 inten direct", v, 32'h3F);
    wr(7'h24, 32'h20); @(negedge clk); chk("R10 irq off after w1c", {31'd0, irq}, 0);

    // R9 parity and index words
    for (int k = 0; k < NPAR; k++) begin
      rd(7'(8'h14 + 4*k), v); chk("R9 parity", v, 32'hA5A5_0000 + 32'(k * 4099));
    end
    for (int k = 0; k < NIDX; k++) begin
      rd(7'(8'h28 + 4*k), v);
      chk("R9 index word", v, {3'd0, idxVal(2*k+1), 3'd0, idxVal(2*k)});
    end
    rd(7'h44, v); chk("R9 unmapped", v, 0);

    // R4 zero count never completes
    startPass(1'b1, 32'd0);
    wr(7'h10, 32'h12);
    rd(7'h24, v); chk("R4 zero count", v, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule